// File: doc/BRIEF.md
# Programmable Status LED Controller

This block turns a PHY's status signals into indications on a row of open-drain, active-low LED pins. Each pin has a fixed default meaning: 100 Mb/s link, packet activity or full duplex. A 3-bit function-select field per pin can point it at another status source, or hold it lit or dark for software-controlled use. Packet activity and collision events last only a few cycles, so they pass through a retriggerable stretcher. The stretcher keeps the indication lit for a fixed hold time, 100 ms by default, derived from the core clock frequency.

The same pins also serve as reset-time address straps. While reset is asserted and the block is not yet armed, no pin is pulled low, so the external resistor sets the level. On the first clock edge after reset is released, the level seen on each pin is latched as one bit of the management device address. The pins start driving on the cycle that follows. The analog pad and the register file that holds the select fields are outside the block.

Top module: `status_led_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge after it goes high, every bit of `led_drive_low_o` is 0, so the pins stay high impedance.
- R2: On the first rising clock edge with `rst_n` high, `strap_addr_o[i]` takes the level of `led_pad_i[i]`. Later changes on `led_pad_i` have no effect on `strap_addr_o` until the next reset.
- R3: Select code 0 gives each pin its default function: pin 0 shows 100 Mb/s link, pin 1 shows stretched activity, pin 2 shows full duplex.
- R4: An activity event (`tx_pkt_i` or `rx_pkt_i` high at a clock edge) lights the activity indication for exactly HOLD cycles after that edge, where HOLD = CLK_HZ*HOLD_MS/1000. A new event during the hold restarts the full HOLD window.
- R5: Select code 1 shows `link100_i`, code 3 shows `full_dup_i`, and code 5 shows `speed100_i`. Each is lit when its input is 1.
- R6: Select code 4 shows collision (`col_i`), stretched by the same HOLD window and the same restart rule as activity. Code 2 shows stretched activity.
- R7: Select code 6 forces the pin lit and code 7 forces it dark, whatever the status inputs are.
- R8: Outputs are active low: a lit indication sets `led_drive_low_o[i]` to 1, which pulls the pin to 0. A dark indication sets it to 0, which releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link100_i | input | 1 | 100 Mb/s link is up |
| full_dup_i | input | 1 | Link runs full duplex |
| speed100_i | input | 1 | Link speed is 100 Mb/s |
| tx_pkt_i | input | 1 | Transmit packet event |
| rx_pkt_i | input | 1 | Receive packet event |
| col_i | input | 1 | Collision event |
| led_sel_i | input | NUM_LEDS*3 | Function-select field per pin, 3 bits each, pin i in bits [3i+2:3i] |
| led_pad_i | input | NUM_LEDS | Level sensed on each pin |
| led_drive_low_o | output | NUM_LEDS | 1 = pull pin low (lit), 0 = high impedance |
| strap_addr_o | output | NUM_LEDS | Address bits captured from the pins at reset release |

## Verification
The assertions assume that all status and event inputs are synchronous to `clk`. They also assume that `led_sel_i` is a steady register value, and that `led_pad_i` is a valid level at the edge where reset is released. The bench drives every input on the falling clock edge and holds the select fields constant while it samples. It applies the pad levels before it releases reset. The stretcher checks assume that an event is judged only at rising edges. The bench therefore gives each event pulse exactly one rising edge.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;
   typedef enum logic [2:0] {
      FN_DEFAULT = 3'd0,
      FN_LINK100 = 3'd1,
      FN_ACT     = 3'd2,
      FN_FDX     = 3'd3,
      FN_COL     = 3'd4,
      FN_SPD100  = 3'd5,
      FN_ON      = 3'd6,
      FN_OFF     = 3'd7
   } led_fn_e;

   localparam int FN_W = 3;
endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int HOLD_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   output logic lit_o
);
   localparam int CW = $clog2(HOLD_CYC + 1);

   logic [CW-1:0] cnt_q;

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("led_stretch: HOLD_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (evt_i)
         cnt_q <= CW'(HOLD_CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign lit_o = (cnt_q != '0);

   // R4 / R6: an event lights the indication on the next cycle
   a_r4_event_lights: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> lit_o);

   // R4: an event-free cycle with time left keeps the indication lit
   a_r4_hold_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i && cnt_q > CW'(1)) |=> lit_o);

   // R4: the last cycle of the window ends the indication
   a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i && cnt_q == CW'(1)) |=> !lit_o);
endmodule

// File: rtl/led_fn_mux.sv
module led_fn_mux
   import led_ctrl_pkg::*;
#(
   parameter logic [FN_W-1:0] DEF_FN = 3'd1
) (
   input  logic [FN_W-1:0] sel_i,
   input  logic            link100_i,
   input  logic            full_dup_i,
   input  logic            speed100_i,
   input  logic            act_lit_i,
   input  logic            col_lit_i,
   output logic            on_o
);
   led_fn_e eff_fn;

   always_comb begin
      eff_fn = (sel_i == FN_DEFAULT) ? led_fn_e'(DEF_FN) : led_fn_e'(sel_i);
      unique case (eff_fn)
         FN_LINK100: on_o = link100_i;
         FN_ACT:     on_o = act_lit_i;
         FN_FDX:     on_o = full_dup_i;
         FN_COL:     on_o = col_lit_i;
         FN_SPD100:  on_o = speed100_i;
         FN_ON:      on_o = 1'b1;
         FN_OFF:     on_o = 1'b0;
         default:    on_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/status_led_ctrl.sv
module status_led_ctrl
   import led_ctrl_pkg::*;
#(
   parameter int NUM_LEDS = 3,
   parameter int CLK_HZ   = 25_000_000,
   parameter int HOLD_MS  = 100,
   parameter logic [NUM_LEDS*FN_W-1:0] DEF_FN = {3'd3, 3'd2, 3'd1}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     link100_i,
   input  logic                     full_dup_i,
   input  logic                     speed100_i,
   input  logic                     tx_pkt_i,
   input  logic                     rx_pkt_i,
   input  logic                     col_i,
   input  logic [NUM_LEDS*FN_W-1:0] led_sel_i,
   input  logic [NUM_LEDS-1:0]      led_pad_i,
   output logic [NUM_LEDS-1:0]      led_drive_low_o,
   output logic [NUM_LEDS-1:0]      strap_addr_o
);
   localparam longint HOLD_L   = (longint'(CLK_HZ) * longint'(HOLD_MS)) / 1000;
   localparam int     HOLD_CYC = int'(HOLD_L);

   if (NUM_LEDS < 1 || NUM_LEDS > 16) begin : g_bad_num
      $error("status_led_ctrl: NUM_LEDS out of range 1..16");
   end
   if (HOLD_CYC < 1) begin : g_bad_clk
      $error("status_led_ctrl: CLK_HZ*HOLD_MS too small");
   end

   logic                armed_q;
   logic [NUM_LEDS-1:0] strap_q;
   logic [NUM_LEDS-1:0] on_w;
   logic                act_lit;
   logic                col_lit;

   // Strap capture on the first edge out of reset; driving starts after it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         strap_q <= '0;
      end else if (!armed_q) begin
         armed_q <= 1'b1;
         strap_q <= led_pad_i;
      end
   end

   led_stretch #(.HOLD_CYC(HOLD_CYC)) i_act_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (tx_pkt_i | rx_pkt_i),
      .lit_o (act_lit)
   );

   led_stretch #(.HOLD_CYC(HOLD_CYC)) i_col_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (col_i),
      .lit_o (col_lit)
   );

   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      if (DEF_FN[i*FN_W +: FN_W] == FN_DEFAULT) begin : g_bad_def
         $error("status_led_ctrl: default function of a pin may not be code 0");
      end

      led_fn_mux #(.DEF_FN(DEF_FN[i*FN_W +: FN_W])) i_mux (
         .sel_i      (led_sel_i[i*FN_W +: FN_W]),
         .link100_i  (link100_i),
         .full_dup_i (full_dup_i),
         .speed100_i (speed100_i),
         .act_lit_i  (act_lit),
         .col_lit_i  (col_lit),
         .on_o       (on_w[i])
      );

      // R7: forced codes win once the pins are driving
      a_r7_force_on: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && led_sel_i[i*FN_W +: FN_W] == FN_ON) |-> led_drive_low_o[i]);
      a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
         (led_sel_i[i*FN_W +: FN_W] == FN_OFF) |-> !led_drive_low_o[i]);
   end

   assign led_drive_low_o = armed_q ? on_w : '0;
   assign strap_addr_o    = strap_q;

   // R1: no pin is pulled low while reset is applied
   always @(posedge clk) begin
      if (!rst_n)
         a_r1_hiz_in_reset: assert (led_drive_low_o == '0);
   end

   // R2: the captured address holds once the pins are driving
   a_r2_strap_stable: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> $stable(strap_addr_o));
endmodule

// File: tb/test_status_led_ctrl.sv
module test_status_led_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 3;
   localparam int HOLD       = 20;   // 200 Hz * 100 ms

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           link100 = 0, fdx = 0, spd = 0, txp = 0, rxp = 0, col = 0;
   logic [N*3-1:0] sel = '0;
   logic [N-1:0]   pad = '0;
   logic [N-1:0]   drv;
   logic [N-1:0]   strap;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   status_led_ctrl #(.NUM_LEDS(N), .CLK_HZ(200), .HOLD_MS(100)) i_status_led_ctrl (
      .clk(clk), .rst_n(rst_n), .link100_i(link100), .full_dup_i(fdx),
      .speed100_i(spd), .tx_pkt_i(txp), .rx_pkt_i(rxp), .col_i(col),
      .led_sel_i(sel), .led_pad_i(pad), .led_drive_low_o(drv), .strap_addr_o(strap)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // vector: {sel0[2:0], link100, fdx, spd, expected drive of pin 0}
   localparam int NV = 13;
   localparam logic [6:0] VEC [NV] = '{
      {3'd0, 1'b1, 1'b0, 1'b0, 1'b1},   // R3 default pin0 = link
      {3'd0, 1'b0, 1'b1, 1'b1, 1'b0},   // R3
      {3'd1, 1'b1, 1'b0, 1'b0, 1'b1},   // R5 link
      {3'd1, 1'b0, 1'b1, 1'b1, 1'b0},   // R5
      {3'd3, 1'b0, 1'b1, 1'b0, 1'b1},   // R5 duplex
      {3'd3, 1'b1, 1'b0, 1'b1, 1'b0},   // R5
      {3'd5, 1'b0, 1'b0, 1'b1, 1'b1},   // R5 speed
      {3'd5, 1'b1, 1'b1, 1'b0, 1'b0},   // R5
      {3'd6, 1'b0, 1'b0, 1'b0, 1'b1},   // R7 on
      {3'd7, 1'b1, 1'b1, 1'b1, 1'b0},   // R7 off
      {3'd2, 1'b1, 1'b1, 1'b1, 1'b0},   // R6 activity, idle
      {3'd4, 1'b1, 1'b1, 1'b1, 1'b0},   // R6 collision, idle
      {3'd6, 1'b1, 1'b1, 1'b1, 1'b1}    // R8 lit drives low
   };

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      pad = 3'b101;
      sel = {3'd0, 3'd0, 3'd0};
      link100 = 1; fdx = 1;
      tick(3);
      chk("R1 in reset", drv, 3'b000);
      rst_n = 1'b1;                 // released at negedge
      #1 chk("R1 before capture edge", drv, 3'b000);
      tick(1);
      chk("R2 strap captured", strap, 3'b101);
      chk("R3 defaults link/idle/duplex", drv, 3'b101);
      pad = 3'b010;
      tick(2);
      chk("R2 strap ignores later pad", strap, 3'b101);

      for (int v = 0; v < NV; v++) begin
         sel = {3'd7, 3'd7, VEC[v][6:4]};
         link100 = VEC[v][3]; fdx = VEC[v][2]; spd = VEC[v][1];
         #1 chk($sformatf("R5/R7 vector %0d", v), drv, {2'b00, VEC[v][0]});
      end

      // R4 activity stretch on default pin1 (other pins off)
      sel = {3'd7, 3'd0, 3'd7};
      txp = 1; tick(1); txp = 0;
      chk("R4 lit after event", drv, 3'b010);
      tick(HOLD - 1);
      chk("R4 lit at last hold cycle", drv, 3'b010);
      tick(1);
      chk("R4 dark after hold", drv, 3'b000);

      // R4 restart via receive event
      rxp = 1; tick(1); rxp = 0;
      tick(10);
      rxp = 1; tick(1); rxp = 0;
      tick(HOLD - 1);
      chk("R4 restart keeps lit", drv, 3'b010);
      tick(1);
      chk("R4 dark after restarted hold", drv, 3'b000);

      // R6 collision stretch on pin2 via code 4
      sel = {3'd4, 3'd7, 3'd7};
      col = 1; tick(1); col = 0;
      chk("R6 collision lit", drv, 3'b100);
      tick(HOLD - 1);
      chk("R6 collision lit last cycle", drv, 3'b100);
      tick(1);
      chk("R6 collision dark", drv, 3'b000);

      // R6 activity via code 2 on pin0
      sel = {3'd7, 3'd7, 3'd2};
      txp = 1; tick(1); txp = 0;
      chk("R6 activity code 2", drv, 3'b001);

      // R1/R2 second reset with a new strap
      pad = 3'b011;
      rst_n = 1'b0;
      #1 chk("R1 reset releases pins", drv, 3'b000);
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk("R2 new strap", strap, 3'b011);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule